// File: doc/BRIEF.md
# Folded-Tag GMAC Authentication Engine

This block computes a GMAC authentication value over a stream of associated data followed by message data and returns it folded to 64 bits. The caller starts a message with a one-cycle `start` pulse that carries a 64-bit per-message IV and the 128-bit hash subkey. The engine turns the IV into a 96-bit nonce on `nonce`. An external cipher unit uses that nonce to produce the encrypted initial counter block and returns it on `ek_j0`. The engine itself contains no block cipher.

Data arrives as 128-bit beats on a valid/ready stream. Each beat carries a byte count from 0 to 16 and a phase bit that marks it as associated data or message data. All associated-data beats come first. The message ends with the beat that has both the message phase and the last flag set. Each non-empty beat is zero-padded and folded into the hash accumulator by a bit-serial multiplier over GF(2^128). Once the message data is in, a length block is absorbed. The result is XORed with `ek_j0` and its two 64-bit halves are XORed together to form the tag.

Top module: `gmac_fold_engine`

## Requirements
- R1: On the clock edge where `start` is high, `iv` and `h_key` are captured. From the next cycle on, `nonce` equals the captured IV in bits 95:32 with bits 31:0 zero.
- R2: `start` has priority in every state. It clears the accumulator and both length counts and drops any message in progress, which then produces no `tag_valid`. A fresh message after it gives the correct tag.
- R3: Every non-empty beat X updates the accumulator as Y = (Y xor X) * H over GF(2^128) with the reflected polynomial x^128 + x^7 + x^2 + x + 1. Stream byte 0 sits in `s_data[127:120]`, and bit 127 of a block is the coefficient of x^0.
- R4: Bytes at positions at or above `s_bytes` in a beat are replaced by zero before absorption. Partial associated data is therefore padded to a 16-byte boundary, and the content of those byte lanes has no effect on the tag.
- R5: Beats with `s_is_msg`=0 count toward the associated-data length, and beats with `s_is_msg`=1 count toward the message length. `s_last` on an associated-data beat has no effect.
- R6: A beat with `s_bytes`=0 absorbs nothing and adds no length. Associated data may be empty. An empty message is sent as one zero-byte beat with `s_is_msg`=1 and `s_last`=1.
- R7: After the final message beat, the block {associated-data bit length[63:0], message bit length[63:0]} is absorbed. The result is XORed with `ek_j0`, which is sampled on the edge where that multiplication completes.
- R8: `tag` equals bits 127:64 XOR bits 63:0 of the value from R7.
- R9: `s_ready` is high only while the engine waits for data. After each beat with a non-zero byte count it goes low for exactly 129 cycles, or longer when the beat ends the message. A zero-byte beat that is not a final message beat leaves it high.
- R10: `tag_valid` is a one-cycle pulse, issued 129 cycles after the final data multiplication finishes, or 129 cycles after an empty final beat is accepted. `s_ready` stays low from then until the next `start`.
- R11: After reset, `s_ready`, `tag_valid` and `tag` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a new message; captures `iv` and `h_key` |
| iv | input | 64 | Per-message IV |
| h_key | input | 128 | Hash subkey H |
| ek_j0 | input | 128 | Encrypted initial counter block |
| nonce | output | 96 | Zero-extended IV for the external cipher unit |
| s_valid | input | 1 | Beat valid |
| s_ready | output | 1 | Engine accepts a beat |
| s_data | input | 128 | Beat data, byte 0 in bits 127:120 |
| s_bytes | input | 5 | Valid bytes in the beat, 0 to 16 |
| s_is_msg | input | 1 | 0 = associated data, 1 = message data |
| s_last | input | 1 | Final beat, honoured on message beats only |
| tag | output | 64 | Folded tag |
| tag_valid | output | 1 | One-cycle tag strobe |

## Verification
An accumulator corrupted in any single bit, a wrong padding mask or a miscounted length shows up only in `tag`, and only at the end of the message. The bench therefore compares every tag against a spec-level reference, plus two published known-answer values. A multiplier or state machine that runs one cycle long or short changes when `s_ready` rises on the very next beat, so readiness and `tag_valid` are compared against a behavioural cycle model on every clock. An abort that is not handled properly shows up as a stray `tag_valid` pulse or a wrong tag on the next message.

// File: rtl/gmac_pkg.sv
// Shared constants, state type and tag folding for the folded-tag GMAC engine.
// Assumes 128-bit blocks and GCM bit order (bit 127 = coefficient of x^0).
package gmac_pkg;
    localparam int BLK_W   = 128;
    localparam int IV_W    = 64;
    localparam int NONCE_W = 96;
    localparam int TAG_W   = BLK_W / 2;
    localparam int LEN_W   = 64;
    localparam int NBYTES  = BLK_W / 8;
    localparam int BYTES_W = $clog2(NBYTES) + 1;
    localparam int CNT_W   = $clog2(BLK_W);

    // Reduction constant of x^128 + x^7 + x^2 + x + 1 in reflected order
    localparam logic [BLK_W-1:0] GF_R = {8'hE1, {(BLK_W-8){1'b0}}};

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAKE = 2'd1,
        ST_DATA = 2'd2,
        ST_LEN  = 2'd3
    } eng_state_t;

    // XOR the two halves of a block into a half-width tag
    function automatic logic [TAG_W-1:0] fold_half(input logic [BLK_W-1:0] v);
        return v[BLK_W-1:TAG_W] ^ v[TAG_W-1:0];
    endfunction
endpackage

// File: rtl/gf128_serial_mul.sv
// Bit-serial GF(2^W) multiplier in reflected bit order.
// A load starts a W-cycle product of a and b; done pulses one cycle after the
// last step, with prod holding the result. Abort cancels a product in flight.
// Assumes a and b are held only for the load cycle (both are registered).
module gf128_serial_mul #(
    parameter int              W      = 128,
    parameter logic [W-1:0]    POLY_R = {8'hE1, {(W-8){1'b0}}}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         abort,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] prod
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  z_q;
    logic [W-1:0]  v_q;
    logic [W-1:0]  bsh_q;
    logic [CW-1:0] step_q;

    // One multiply-accumulate and one reduction step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q    <= '0;
            v_q    <= '0;
            bsh_q  <= '0;
            step_q <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (load) begin
                z_q    <= '0;
                v_q    <= a;
                bsh_q  <= b;
                step_q <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                if (bsh_q[W-1]) z_q <= z_q ^ v_q;
                v_q    <= v_q[0] ? ((v_q >> 1) ^ POLY_R) : (v_q >> 1);
                bsh_q  <= bsh_q << 1;
                step_q <= step_q + 1'b1;
                if (step_q == CW'(W-1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign prod = z_q;
endmodule

// File: rtl/gmac_blk_pad.sv
// Zero-fills the byte lanes of a block at or beyond the valid byte count.
// Byte 0 is the most significant byte. Counts above the lane count keep all lanes.
module gmac_blk_pad #(
    parameter int BLK_W   = 128,
    parameter int BYTES_W = 5
) (
    input  logic [BLK_W-1:0]   din,
    input  logic [BYTES_W-1:0] nbytes,
    output logic [BLK_W-1:0]   dout
);
    localparam int NB = BLK_W / 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        localparam logic [BYTES_W-1:0] IDX = BYTES_W'(i);
        // Keep lane i only when it lies inside the valid count
        assign dout[BLK_W-1-8*i -: 8] = (IDX < nbytes) ? din[BLK_W-1-8*i -: 8] : 8'h00;
    end
endmodule

// File: rtl/gmac_len_track.sv
// Keeps the bit lengths of associated data and message data for the length block.
// Clear has priority over add; each add contributes nbytes*8 to the chosen count.
module gmac_len_track #(
    parameter int LEN_W   = 64,
    parameter int BYTES_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             add_en,
    input  logic             is_msg,
    input  logic [BYTES_W-1:0] nbytes,
    output logic [LEN_W-1:0] aad_bits,
    output logic [LEN_W-1:0] msg_bits
);
    logic [LEN_W-1:0] incr;
    assign incr = {{(LEN_W-BYTES_W-3){1'b0}}, nbytes, 3'b000};

    // Accumulate bit counts per phase
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            aad_bits <= '0;
            msg_bits <= '0;
        end else if (add_en) begin
            if (is_msg) msg_bits <= msg_bits + incr;
            else        aad_bits <= aad_bits + incr;
        end
    end
endmodule

// File: rtl/gmac_fold_engine.sv
// Streaming GMAC engine with a 64-bit folded tag.
// Sequence: start (captures IV and H), associated-data beats, message beats
// ending with s_last, then a length block, the XOR with ek_j0 and the fold.
// Assumes: s_bytes <= 16; only the final beat of each phase is partial;
// ek_j0 stays stable from the final message beat until tag_valid.
module gmac_fold_engine
    import gmac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [IV_W-1:0]      iv,
    input  logic [BLK_W-1:0]     h_key,
    input  logic [BLK_W-1:0]     ek_j0,
    output logic [NONCE_W-1:0]   nonce,
    input  logic                 s_valid,
    output logic                 s_ready,
    input  logic [BLK_W-1:0]     s_data,
    input  logic [BYTES_W-1:0]   s_bytes,
    input  logic                 s_is_msg,
    input  logic                 s_last,
    output logic [TAG_W-1:0]     tag,
    output logic                 tag_valid
);
    eng_state_t       state_q;
    logic [BLK_W-1:0] acc_q;
    logic [BLK_W-1:0] h_q;
    logic [IV_W-1:0]  iv_q;
    logic             pend_last_q;

    logic [BLK_W-1:0] padded;
    logic [LEN_W-1:0] aad_bits;
    logic [LEN_W-1:0] msg_bits;
    logic [BLK_W-1:0] len_blk;
    logic             accept;
    logic             has_data;
    logic             final_beat;
    logic             mul_load;
    logic [BLK_W-1:0] mul_a;
    logic             mul_busy;
    logic             mul_done;
    logic [BLK_W-1:0] mul_prod;

    assign s_ready    = (state_q == ST_TAKE);
    assign accept     = s_valid && s_ready && !start;
    assign has_data   = (s_bytes != '0);
    assign final_beat = s_is_msg && s_last;
    assign len_blk    = {aad_bits, msg_bits};
    assign nonce      = {iv_q, {(NONCE_W-IV_W){1'b0}}};

    gmac_blk_pad #(.BLK_W(BLK_W), .BYTES_W(BYTES_W)) u_pad (
        .din    (s_data),
        .nbytes (s_bytes),
        .dout   (padded)
    );

    gmac_len_track #(.LEN_W(LEN_W), .BYTES_W(BYTES_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .add_en   (accept),
        .is_msg   (s_is_msg),
        .nbytes   (s_bytes),
        .aad_bits (aad_bits),
        .msg_bits (msg_bits)
    );

    // Choose the multiplier operand and when to launch it
    always_comb begin
        mul_load = 1'b0;
        mul_a    = acc_q ^ padded;
        if (!start) begin
            if (state_q == ST_TAKE && accept && has_data) begin
                mul_load = 1'b1;
                mul_a    = acc_q ^ padded;
            end else if (state_q == ST_TAKE && accept && final_beat) begin
                mul_load = 1'b1;
                mul_a    = acc_q ^ len_blk;
            end else if (state_q == ST_DATA && mul_done && pend_last_q) begin
                mul_load = 1'b1;
                mul_a    = mul_prod ^ len_blk;
            end
        end
    end

    gf128_serial_mul #(.W(BLK_W), .POLY_R(GF_R)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (mul_load),
        .abort (start),
        .a     (mul_a),
        .b     (h_q),
        .busy  (mul_busy),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    // Message sequencing: capture on start, absorb, length block, fold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            acc_q       <= '0;
            h_q         <= '0;
            iv_q        <= '0;
            pend_last_q <= 1'b0;
            tag         <= '0;
            tag_valid   <= 1'b0;
        end else begin
            tag_valid <= 1'b0;
            if (start) begin
                state_q     <= ST_TAKE;
                acc_q       <= '0;
                h_q         <= h_key;
                iv_q        <= iv;
                pend_last_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_IDLE: state_q <= ST_IDLE;
                    ST_TAKE: begin
                        if (accept && has_data) begin
                            state_q     <= ST_DATA;
                            pend_last_q <= final_beat;
                        end else if (accept && final_beat) begin
                            state_q <= ST_LEN;
                        end
                    end
                    ST_DATA: begin
                        if (mul_done) begin
                            acc_q   <= mul_prod;
                            state_q <= pend_last_q ? ST_LEN : ST_TAKE;
                        end
                    end
                    ST_LEN: begin
                        if (mul_done) begin
                            acc_q     <= mul_prod;
                            tag       <= fold_half(mul_prod ^ ek_j0);
                            tag_valid <= 1'b1;
                            state_q   <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    logic unused_ok;
    assign unused_ok = mul_busy;
endmodule

// File: rtl/gmac_fold_engine_chk.sv
// Port-level checker for gmac_fold_engine, attached by bind.
// Watches the nonce capture, the length of the busy window and the tag strobe.
module gmac_fold_engine_chk
    import gmac_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [IV_W-1:0]      iv,
    input logic [NONCE_W-1:0]   nonce,
    input logic                 s_valid,
    input logic                 s_ready,
    input logic [BYTES_W-1:0]   s_bytes,
    input logic                 tag_valid
);
    localparam int WIN = BLK_W + 1;

    logic       armed;
    logic [8:0] win;

    // Count the cycles with ready low after a data beat
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            win   <= '0;
        end else if (start) begin
            armed <= 1'b0;
        end else if (s_valid && s_ready && s_bytes != '0) begin
            armed <= 1'b1;
            win   <= '0;
        end else if (armed) begin
            if (s_ready) armed <= 1'b0;
            else         win   <= win + 1'b1;
        end
    end

    // R1: nonce reflects the IV captured at start, zero-extended
    a_r1_nonce_capture: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (nonce == {$past(iv), {(NONCE_W-IV_W){1'b0}}}));

    // R9: a data beat drops ready on the next cycle
    a_r9_busy_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready && s_bytes != '0 && !start) |=> !s_ready);

    // R9: ready comes back after exactly WIN low cycles
    a_r9_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && s_ready) |-> (win == 9'(WIN)));

    // R10: tag strobe lasts one cycle
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |=> !tag_valid);

    // R10: no beat is accepted while the tag is presented
    a_r10_idle_at_tag: assert property (@(posedge clk) disable iff (!rst_n)
        tag_valid |-> !s_ready);

    // R2: start suppresses any tag on the following cycle
    a_r2_start_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !tag_valid);
endmodule

bind gmac_fold_engine gmac_fold_engine_chk u_chk (.*);

// File: tb/tb_gmac_fold_engine.sv
// Self-checking bench: behavioural cycle model for ready/tag_valid compared
// every clock, spec-level GHASH reference and known-answer values for the tag.
module tb_gmac_fold_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [63:0]  iv = '0;
    logic [127:0] h_key = '0;
    logic [127:0] ek_j0 = '0;
    logic [95:0]  nonce;
    logic         s_valid = 1'b0;
    logic         s_ready;
    logic [127:0] s_data = '0;
    logic [4:0]   s_bytes = '0;
    logic         s_is_msg = 1'b0;
    logic         s_last = 1'b0;
    logic [63:0]  tag;
    logic         tag_valid;

    int checks = 0;
    int errors = 0;

    logic [7:0]  aad_b [64];
    logic [7:0]  msg_b [64];
    logic [63:0] exp_tag = '0;
    string       cur_req = "R8";
    int          tags_seen = 0;

    always #2 clk = ~clk;

    gmac_fold_engine dut (.*);

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference GF(2^128) product following the GCM definition
    function automatic logic [127:0] gf_mul(input logic [127:0] x, input logic [127:0] y);
        logic [127:0] z = '0;
        logic [127:0] v = y;
        for (int i = 0; i < 128; i++) begin
            if (x[127-i]) z = z ^ v;
            if (v[0]) v = (v >> 1) ^ {8'hE1, 120'h0};
            else      v = v >> 1;
        end
        return z;
    endfunction

    function automatic logic [63:0] ref_tag(input int na, input int nm,
                                            input logic [127:0] h, input logic [127:0] ek);
        logic [127:0] y = '0;
        logic [127:0] blk;
        logic [127:0] s;
        for (int off = 0; off < na; off += 16) begin
            blk = '0;
            for (int j = 0; j < 16 && off + j < na; j++) blk[127-8*j -: 8] = aad_b[off+j];
            y = gf_mul(y ^ blk, h);
        end
        for (int off = 0; off < nm; off += 16) begin
            blk = '0;
            for (int j = 0; j < 16 && off + j < nm; j++) blk[127-8*j -: 8] = msg_b[off+j];
            y = gf_mul(y ^ blk, h);
        end
        y = gf_mul(y ^ {64'(na * 8), 64'(nm * 8)}, h);
        s = y ^ ek;
        return s[127:64] ^ s[63:0];
    endfunction

    // Behavioural timing model: 0 idle, 1 waiting, 2 busy
    int m_st = 0;
    int m_cnt = 0;
    int m_pend = 0;
    bit m_tv = 1'b0;

    always @(posedge clk) begin
        m_tv = 1'b0;
        if (!rst_n) begin
            m_st = 0; m_pend = 0; m_cnt = 0;
        end else if (start) begin
            m_st = 1; m_pend = 0;
        end else if (m_st == 1) begin
            if (s_valid && s_bytes != 0) begin
                m_st = 2; m_cnt = 129; m_pend = (s_is_msg && s_last) ? 1 : 0;
            end else if (s_valid && s_is_msg && s_last) begin
                m_st = 2; m_cnt = 129; m_pend = 2;
            end
        end else if (m_st == 2) begin
            m_cnt--;
            if (m_cnt == 0) begin
                if (m_pend == 1) begin m_cnt = 129; m_pend = 2; end
                else if (m_pend == 2) begin m_tv = 1'b1; m_st = 0; end
                else m_st = 1;
            end
        end
    end

    // Compare against the model away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R9 ready", 128'(s_ready), 128'(m_st == 1));
            check("R10 tag_valid", 128'(tag_valid), 128'(m_tv));
            if (tag_valid && m_tv) begin
                tags_seen++;
                check(cur_req, 128'(tag), 128'(exp_tag));
            end
        end
    end

    task automatic do_start(input logic [63:0] v, input logic [127:0] h, input logic [127:0] ek);
        @(negedge clk);
        start = 1'b1; iv = v; h_key = h; ek_j0 = ek;
        @(negedge clk);
        start = 1'b0;
        check("R1 nonce", 128'(nonce), 128'({v, 32'h0}));
    endtask

    task automatic send_beat(input logic [127:0] d, input int nb, input bit msg, input bit last);
        @(negedge clk);
        s_valid = 1'b1; s_data = d; s_bytes = 5'(nb); s_is_msg = msg; s_last = last;
        while (!s_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_valid = 1'b0; s_last = 1'b0;
    endtask

    // Build one beat; lanes beyond the count get filler (zero or garbage)
    function automatic logic [127:0] mk_beat(input bit msg, input int off, input int nb, input bit junk);
        logic [127:0] d = '0;
        for (int j = 0; j < 16; j++)
            if (j < nb) d[127-8*j -: 8] = msg ? msg_b[off+j] : aad_b[off+j];
            else if (junk) d[127-8*j -: 8] = 8'hA5 ^ 8'(j);
        return d;
    endfunction

    task automatic send_msg(input int na, input int nm, input bit junk, input bit aad_last);
        int nb;
        for (int off = 0; off < na; off += 16) begin
            nb = (na - off > 16) ? 16 : na - off;
            send_beat(mk_beat(1'b0, off, nb, junk), nb, 1'b0, aad_last);
        end
        if (nm == 0) send_beat(junk ? {4{32'hDEADBEEF}} : '0, 0, 1'b1, 1'b1);
        for (int off = 0; off < nm; off += 16) begin
            nb = (nm - off > 16) ? 16 : nm - off;
            send_beat(mk_beat(1'b1, off, nb, junk), nb, 1'b1, off + 16 >= nm);
        end
    endtask

    task automatic wait_tag(input string req);
        int n0 = tags_seen;
        int guard = 0;
        while (tags_seen == n0 && guard < 2000) begin @(negedge clk); guard++; end
        check(req, 128'(tags_seen - n0), 128'(1));
    endtask

    initial begin
        logic [127:0] hk = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
        logic [127:0] ek = 128'h58e2fccefa7e3061367f1d57a4e7455a;
        logic [127:0] h2 = 128'h0123456789abcdeffedcba9876543210;
        logic [127:0] e2 = 128'h00ff00ff11ee22dd33cc44bb55aa6699;
        logic [127:0] c0 = 128'h0388dace60b6a392f328c2b971b2fe78;
        int           n_before;

        for (int i = 0; i < 64; i++) begin
            aad_b[i] = 8'(i * 37 + 5);
            msg_b[i] = 8'(i * 91 + 17);
        end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check("R11 ready", 128'(s_ready), 128'(0));
        check("R11 tag_valid", 128'(tag_valid), 128'(0));
        check("R11 tag", 128'(tag), 128'(0));

        // R6/R7/R8: empty data, known answer
        do_start(64'h0, hk, ek);
        exp_tag = 64'h6e9de1995e99753b; cur_req = "R6 R7 R8 empty message";
        check("R8 reference", 128'(ref_tag(0, 0, hk, ek)), 128'(exp_tag));
        send_msg(0, 0, 1'b1, 1'b0);
        wait_tag("R10 one tag");

        // R3/R7: one full block, known answer
        for (int j = 0; j < 16; j++) msg_b[j] = c0[127-8*j -: 8];
        do_start(64'h0, hk, ek);
        exp_tag = 64'h5e5420663ebbae62; cur_req = "R3 R7 single block";
        check("R3 reference", 128'(ref_tag(0, 16, hk, ek)), 128'(exp_tag));
        send_msg(0, 16, 1'b0, 1'b0);
        wait_tag("R10 one tag");
        for (int j = 0; j < 16; j++) msg_b[j] = 8'(j * 91 + 17);

        // R4/R5: partial associated data, multi-block message with partial tail
        do_start(64'h1122334455667788, h2, e2);
        exp_tag = ref_tag(20, 33, h2, e2); cur_req = "R4 R5 partial blocks";
        send_msg(20, 33, 1'b0, 1'b0);
        wait_tag("R10 one tag");

        // R4/R5: same lengths, garbage in unused lanes and last on AAD beats
        do_start(64'hcafef00d12345678, h2, e2);
        cur_req = "R4 R5 garbage lanes ignored";
        send_msg(20, 33, 1'b1, 1'b1);
        wait_tag("R10 one tag");

        // R6: empty associated data, 5-byte message, zero-byte AAD beat in front
        do_start(64'h0f0f0f0f0f0f0f0f, hk, e2);
        exp_tag = ref_tag(0, 5, hk, e2); cur_req = "R6 empty aad";
        send_beat({4{32'h5a5a5a5a}}, 0, 1'b0, 1'b0);
        check("R6 zero beat keeps ready", 128'(s_ready), 128'(1));
        send_msg(0, 5, 1'b1, 1'b0);
        wait_tag("R10 one tag");

        // R2: abort in the middle, then a fresh message
        do_start(64'haaaa5555aaaa5555, h2, ek);
        n_before = tags_seen;
        send_beat(mk_beat(1'b0, 0, 16, 1'b0), 16, 1'b0, 1'b0);
        repeat (40) @(negedge clk);
        do_start(64'h5555aaaa5555aaaa, h2, ek);
        repeat (300) @(negedge clk);
        check("R2 no tag after abort", 128'(tags_seen), 128'(n_before));
        exp_tag = ref_tag(32, 17, h2, ek); cur_req = "R2 fresh after abort";
        send_msg(32, 17, 1'b0, 1'b0);
        wait_tag("R10 one tag");

        // R10: engine stays idle after the tag
        repeat (5) @(negedge clk);
        check("R10 idle after tag", 128'(s_ready), 128'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule